// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

After a master has written to a serial memory and sent the Stop that starts the device's internal write cycle, this sequencer finds out when that cycle has ended. It does not wait out a fixed worst-case delay. Instead it keeps addressing the device until the device responds. The sequencer sits above a byte-level I2C master engine and issues one command at a time: Start, a byte, or Stop. The engine reports when each command has finished and whether the addressed device acknowledged the byte.

A single-cycle `go` starts a sequence, and the first Start is issued at once. Each attempt is a Start followed by the device's write control byte. A missing acknowledge means the device is still busy. The sequencer then sends a Stop and tries again. An acknowledge means the write has completed. The sequencer then reports completion at once and sends no Stop, so the caller can continue with its next read or write on the open bus. A maximum attempt count caps the loop. When the cap is reached, the sequence ends with an error flag. In every case, the number of attempts is held in a status output.

Top module: `apoll_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `err`, `cmd_req` and `poll_count` are all 0, and `cmd_op` is 0 (no command).
- R2: Every attempt issues a Start command (`cmd_op`=1) and then a byte command (`cmd_op`=2) whose `cmd_data` holds the device address latched at `go` in bits 7:1 and a 0 (write) in bit 0.
- R3: In the cycle right after `go` is accepted, `cmd_req` is high with `cmd_op`=1 (Start).
- R4: When the engine reports that the control byte was not acknowledged (`cmd_nack`=1 with `cmd_fin`) and the attempt limit is not yet reached, the sequencer issues a Stop (`cmd_op`=3) and then begins a new attempt with a Start.
- R5: When the control byte is acknowledged, the sequence ends with `err`=0 and no further command, not even a Stop.
- R6: At the end of a sequence, `poll_count` holds the number of control bytes sent during that sequence, and it keeps that value until the next sequence ends.
- R7: The attempt limit is `max_polls` sampled at `go`, and a value of 0 counts as 1. When that many attempts have all been refused, the sequencer issues a final Stop and ends with `err`=1 and `poll_count` equal to the limit.
- R8: `done` is a one-cycle pulse. It is high in the cycle after the `cmd_fin` of the sequence's last command, and `busy` is already low in that cycle.
- R9: A `go` that arrives while `busy` is high has no effect: the running sequence keeps its address and limit, and it produces exactly one `done`.
- R10: With the default `STICKY_ERR`=1, `err` stays high after a timeout until the next accepted `go`. In the cycle after that `go`, `err` reads 0.
- R11: `cmd_req` lasts one cycle, and no new request is made until the engine has answered the previous one with `cmd_fin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | One-cycle request to start polling |
| dev_addr | input | 7 | Device address, sampled at an accepted `go` |
| max_polls | input | CNT_W | Attempt limit, sampled at an accepted `go` (0 acts as 1) |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | The last sequence ended by hitting the attempt limit |
| poll_count | output | CNT_W | Attempts made in the last finished sequence |
| cmd_req | output | 1 | One-cycle command request to the byte engine |
| cmd_op | output | 2 | Command: 1 Start, 2 byte, 3 Stop, 0 none |
| cmd_data | output | 8 | Byte for a byte command |
| cmd_fin | input | 1 | One-cycle pulse from the engine when a command has finished |
| cmd_nack | input | 1 | With `cmd_fin`: the byte was not acknowledged |

## Verification
The first Start request is due one cycle after `go` is accepted. The bench therefore samples `cmd_req` and `cmd_op` at the first falling edge after the edge that takes `go`. `done`, `err` and `poll_count` are due exactly one cycle after the engine's last `cmd_fin`. The engine model stamps the cycle of every `cmd_fin`, and the bench compares the cycle in which it sees `done` with that stamp plus one, rather than merely waiting for the pulse. The engine's answer latency is drawn at random for each command. After `done`, the bench watches a further idle window for any stray command or pulse, and only then does it compare the logged command stream with the stream computed from the refusal count and the limit.

// File: rtl/apoll_pkg.sv
package apoll_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_START = 2'd1,
      OP_BYTE  = 2'd2,
      OP_STOP  = 2'd3
   } apoll_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISS_START,
      ST_WT_START,
      ST_ISS_CTRL,
      ST_WT_CTRL,
      ST_ISS_STOP,
      ST_WT_STOP
   } apoll_state_e;

   localparam int unsigned ADDR_W = 7;

endpackage

// File: rtl/apoll_tries.sv
module apoll_tries #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit_in,
   output logic [CNT_W-1:0] cnt_nx,
   output logic             spent
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;

   always_comb begin
      cnt_nx = cnt_q;
      if (clr)
         cnt_nx = '0;
      else if (inc && cnt_q != FULL)
         cnt_nx = cnt_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= ONE;
      end else begin
         cnt_q <= cnt_nx;
         if (clr)
            lim_q <= (limit_in == '0) ? ONE : limit_in;
      end
   end

   assign spent = (cnt_q >= lim_q);

endmodule

// File: rtl/apoll_ctl.sv
module apoll_ctl
   import apoll_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go,
   input  logic      fin,
   input  logic      nack,
   input  logic      spent,
   output logic      launch,
   output logic      try_inc,
   output logic      end_ok,
   output logic      end_to,
   output logic      busy,
   output logic      req,
   output apoll_op_e op
);
   apoll_state_e st_q, st_d;

   always_comb begin
      st_d    = st_q;
      launch  = 1'b0;
      try_inc = 1'b0;
      end_ok  = 1'b0;
      end_to  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (go) begin
               launch = 1'b1;
               st_d   = ST_ISS_START;
            end
         end
         ST_ISS_START: st_d = ST_WT_START;
         ST_WT_START:  if (fin) st_d = ST_ISS_CTRL;
         ST_ISS_CTRL:  st_d = ST_WT_CTRL;
         ST_WT_CTRL: begin
            if (fin) begin
               try_inc = 1'b1;
               if (!nack) begin
                  end_ok = 1'b1;
                  st_d   = ST_IDLE;
               end else begin
                  st_d = ST_ISS_STOP;
               end
            end
         end
         ST_ISS_STOP:  st_d = ST_WT_STOP;
         ST_WT_STOP: begin
            if (fin) begin
               if (spent) begin
                  end_to = 1'b1;
                  st_d   = ST_IDLE;
               end else begin
                  st_d = ST_ISS_START;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      req = 1'b1;
      op  = OP_NONE;
      unique case (st_q)
         ST_ISS_START: op = OP_START;
         ST_ISS_CTRL:  op = OP_BYTE;
         ST_ISS_STOP:  op = OP_STOP;
         default:      req = 1'b0;
      endcase
   end

   assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/apoll_status.sv
module apoll_status #(
   parameter int unsigned CNT_W      = 8,
   parameter bit          STICKY_ERR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             end_ok,
   input  logic             end_to,
   input  logic [CNT_W-1:0] cnt_nx,
   output logic             done,
   output logic             err,
   output logic [CNT_W-1:0] poll_count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         poll_count <= '0;
      end else begin
         done <= end_ok | end_to;
         if (end_ok | end_to)
            poll_count <= cnt_nx;
      end
   end

   generate
      if (STICKY_ERR) begin : g_err_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               err <= 1'b0;
            else if (end_to)
               err <= 1'b1;
            else if (launch | end_ok)
               err <= 1'b0;
         end
      end else begin : g_err_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err <= 1'b0;
            else        err <= end_to;
         end
      end
   endgenerate

endmodule

// File: rtl/apoll_seq.sv
module apoll_seq
   import apoll_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter bit          STICKY_ERR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [6:0]       dev_addr,
   input  logic [CNT_W-1:0] max_polls,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic [CNT_W-1:0] poll_count,
   output logic             cmd_req,
   output logic [1:0]       cmd_op,
   output logic [7:0]       cmd_data,
   input  logic             cmd_fin,
   input  logic             cmd_nack
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("apoll_seq: CNT_W must lie in 2..16");
      end
   endgenerate

   logic             launch, try_inc, end_ok, end_to, spent;
   logic [CNT_W-1:0] cnt_nx;
   logic [ADDR_W-1:0] addr_q;
   apoll_op_e        op_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (launch) addr_q <= dev_addr;
   end

   apoll_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .fin     (cmd_fin),
      .nack    (cmd_nack),
      .spent   (spent),
      .launch  (launch),
      .try_inc (try_inc),
      .end_ok  (end_ok),
      .end_to  (end_to),
      .busy    (busy),
      .req     (cmd_req),
      .op      (op_e)
   );

   apoll_tries #(.CNT_W(CNT_W)) u_tries (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (launch),
      .inc      (try_inc),
      .limit_in (max_polls),
      .cnt_nx   (cnt_nx),
      .spent    (spent)
   );

   apoll_status #(.CNT_W(CNT_W), .STICKY_ERR(STICKY_ERR)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .end_ok     (end_ok),
      .end_to     (end_to),
      .cnt_nx     (cnt_nx),
      .done       (done),
      .err        (err),
      .poll_count (poll_count)
   );

   assign cmd_op   = op_e;
   assign cmd_data = {addr_q, 1'b0};

endmodule

// File: rtl/apoll_seq_chk.sv
module apoll_seq_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [CNT_W-1:0] max_polls,
   input logic             busy,
   input logic             done,
   input logic             err,
   input logic [CNT_W-1:0] poll_count,
   input logic             cmd_req,
   input logic [1:0]       cmd_op,
   input logic [7:0]       cmd_data,
   input logic             cmd_fin
);
   logic             open_q;
   logic [CNT_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         lim_q  <= CNT_W'(1);
      end else begin
         if (cmd_req)      open_q <= 1'b1;
         else if (cmd_fin) open_q <= 1'b0;
         if (go && !busy)
            lim_q <= (max_polls == '0) ? CNT_W'(1) : max_polls;
      end
   end

   p_idle_reset_r1: assert property (@(posedge clk) !rst_n |-> !busy && !done && !cmd_req);
   p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && cmd_op == 2'd2 |-> cmd_data[0] == 1'b0);
   p_start_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go && !busy |=> cmd_req && cmd_op == 2'd1);
   p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> poll_count <= lim_q);
   p_timeout_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done && err |-> poll_count == lim_q);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_after_fin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(cmd_fin) && !busy);
   p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |=> !cmd_req);
   p_req_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> !open_q);

endmodule

bind apoll_seq apoll_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .go         (go),
   .max_polls  (max_polls),
   .busy       (busy),
   .done       (done),
   .err        (err),
   .poll_count (poll_count),
   .cmd_req    (cmd_req),
   .cmd_op     (cmd_op),
   .cmd_data   (cmd_data),
   .cmd_fin    (cmd_fin)
);

// File: tb/apoll_seq_test.sv
`timescale 1ns/1ps
module apoll_seq_test;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             go = 1'b0;
   logic [6:0]       dev_addr = '0;
   logic [CNT_W-1:0] max_polls = '0;
   logic             busy, done, err;
   logic [CNT_W-1:0] poll_count;
   logic             cmd_req;
   logic [1:0]       cmd_op;
   logic [7:0]       cmd_data;
   logic             cmd_fin = 1'b0;
   logic             cmd_nack = 1'b0;

   always #2.5 clk = ~clk;

   apoll_seq #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr), .max_polls(max_polls),
      .busy(busy), .done(done), .err(err), .poll_count(poll_count),
      .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .cmd_fin(cmd_fin), .cmd_nack(cmd_nack)
   );

   // byte engine and slave model
   int        cyc = 0;
   int        fin_cyc = 0;
   int        seen = 0;
   int        refuse_n = 0;
   int        n_log = 0;
   int        overlap = 0;
   bit        clr = 1'b0;
   bit        pend = 1'b0;
   int        left = 0;
   logic [1:0] op_q = '0;
   logic [1:0] log_op [0:127];
   logic [7:0] log_dat [0:127];

   always @(posedge clk) begin
      cyc     <= cyc + 1;
      cmd_fin <= 1'b0;
      if (clr) begin
         seen    <= 0;
         n_log   <= 0;
         overlap <= 0;
      end else begin
         if (cmd_req && pend) overlap <= overlap + 1;
         if (pend) begin
            if (left == 0) begin
               pend     <= 1'b0;
               cmd_fin  <= 1'b1;
               fin_cyc  <= cyc + 1;
               cmd_nack <= (op_q == 2'd2) && (seen < refuse_n);
               if (op_q == 2'd2) seen <= seen + 1;
            end else begin
               left <= left - 1;
            end
         end else if (cmd_req) begin
            pend <= 1'b1;
            left <= int'($urandom_range(3, 0));
            op_q <= cmd_op;
            if (n_log < 128) begin
               log_op[n_log]  <= cmd_op;
               log_dat[n_log] <= cmd_data;
            end
            n_log <= n_log + 1;
         end
      end
   end

   int total = 0;
   int bad = 0;
   bit hung = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int eff_limit(input int lim);
      return (lim == 0) ? 1 : lim;
   endfunction

   function automatic int exp_polls(input int lim, input int refuse);
      return (refuse < eff_limit(lim)) ? refuse + 1 : eff_limit(lim);
   endfunction

   function automatic bit exp_timeout(input int lim, input int refuse);
      return refuse >= eff_limit(lim);
   endfunction

   task automatic run(input logic [6:0] a, input int lim, input int refuse, input bit poke);
      int polls, n_exp, wait_n, done_cyc, log_n0, log_bad, extra_done;
      bit to;
      polls = exp_polls(lim, refuse);
      to    = exp_timeout(lim, refuse);
      n_exp = to ? 3 * polls : 3 * polls - 1;
      @(negedge clk);
      clr      = 1'b1;
      refuse_n = refuse;
      @(negedge clk);
      clr       = 1'b0;
      go        = 1'b1;
      dev_addr  = a;
      max_polls = CNT_W'(lim);
      @(negedge clk);
      go = 1'b0;
      check(cmd_req === 1'b1 && cmd_op === 2'd1, "R3 start", int'(cmd_op), 1);
      check(err === 1'b0, "R10 err cleared", int'(err), 0);
      wait_n = 0;
      while (done !== 1'b1 && wait_n < 3000) begin
         @(negedge clk);
         wait_n++;
         if (poke && wait_n == 3 && done !== 1'b1) begin
            go        = 1'b1;
            dev_addr  = a ^ 7'h55;
            max_polls = CNT_W'(lim + 3);
         end else begin
            go = 1'b0;
         end
      end
      go = 1'b0;
      if (done !== 1'b1) begin
         hung = 1'b1;
         check(1'b0, "R8 done never seen", 0, 1);
         return;
      end
      done_cyc = cyc;
      check(done_cyc == fin_cyc + 1, "R8 done latency", done_cyc - fin_cyc, 1);
      check(busy === 1'b0, "R8 idle at done", int'(busy), 0);
      check(int'(poll_count) == polls, "R6 poll count", int'(poll_count), polls);
      check(err === to, to ? "R7 timeout err" : "R5 success err", int'(err), int'(to));
      log_n0 = n_log;
      extra_done = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (done === 1'b1) extra_done++;
      end
      check(extra_done == 0, poke ? "R9 single done" : "R8 pulse", extra_done, 0);
      check(n_log == log_n0 && n_log == n_exp, "R5 R4 command count", n_log, n_exp);
      log_bad = 0;
      for (int j = 0; j < n_exp && j < 128; j++) begin
         case (j % 3)
            0: if (log_op[j] !== 2'd1) log_bad++;
            1: if (log_op[j] !== 2'd2 || log_dat[j] !== {a, 1'b0}) log_bad++;
            default: if (log_op[j] !== 2'd3) log_bad++;
         endcase
      end
      check(log_bad == 0, "R2 R4 command stream", log_bad, 0);
      check(overlap == 0, "R11 request overlap", overlap, 0);
      check(err === to, "R10 err held", int'(err), int'(to));
   endtask

   initial begin
      void'($urandom(32'h00c0ffee));
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(!busy && !done && !err && !cmd_req && poll_count == 0 && cmd_op == 0,
               "R1 in reset", int'(busy), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !err && !cmd_req && poll_count == 0, "R1 after reset", int'(cmd_req), 0);

      run(7'h50, 5, 0, 1'b0);
      run(7'h2a, 4, 3, 1'b0);
      run(7'h7f, 4, 4, 1'b0);
      run(7'h01, 0, 0, 1'b0);
      run(7'h33, 0, 2, 1'b0);
      run(7'h44, 6, 2, 1'b1);
      run(7'h12, 2, 9, 1'b1);
      for (int i = 0; i < 24 && !hung; i++)
         run(7'($urandom()), int'($urandom_range(8, 0)), int'($urandom_range(10, 0)),
             1'($urandom_range(1, 0)));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5 * 150000);
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
   end

endmodule